// File: doc/BRIEF.md
# Synchronizable Output Compare Timer

This block is one output compare channel. It has a private 16-bit up-counter and two compare values, a primary and a secondary. Each time the counter is advanced and lands on either value, the block raises a one-cycle match pulse. It also drives a single output pin as a one-shot pulse, as a repeating pulse, or as a PWM waveform. All counting is qualified by a clock-enable input, so the enable sets the time base.

The counter can run on its own or be slaved to one of 21 event lines through a 5-bit source select. With the select at zero the counter is free-running. Any nonzero select slaves the counter to the chosen line, and a mode bit decides how. In synchronous mode each event on the line clears the counter. In trigger mode the counter sits cleared until an event starts it, and it falls back to waiting when its cycle completes.

The counter has three states. In CS_FREE it counts without being armed; this covers both free-running and synchronous operation. CS_ARMED holds the counter at zero and waits for a trigger. In CS_RUN a triggered counter is counting. CS_FREE moves to CS_ARMED when trigger mode is selected. CS_ARMED moves to CS_RUN on the selected event. CS_RUN moves back to CS_ARMED on rollover, at the end of a PWM period, or while a one-shot pulse is complete. CS_ARMED and CS_RUN both return to CS_FREE when trigger mode is left. The output has three states. OS_WAIT drives the pin low and waits for a rising cause. OS_HIGH drives the pin high. OS_DONE is low and latched after a one-shot. OS_WAIT moves to OS_HIGH on a primary match, or on a counter restart in PWM. OS_HIGH moves to OS_DONE on a secondary match in one-shot mode, and to OS_WAIT on a secondary match in repeat mode or on a primary match in PWM. OS_DONE moves to OS_WAIT on `arm`, or when a mode other than one-shot is selected.

Top module: `occh_timer`

## Requirements
- R1: The counter is 16 bits wide and advances by one on each counted cycle, wrapping from FFFFh to 0000h. With `src_sel` = 0 it free-runs and ignores every event line. With pri=5 and sec=9, match pulses recur 65536 cycles apart.
- R2: A `src_sel` value v in 1..21 selects bit v-1 of `sync_src`, and the other lines have no effect. Values 22..31 select no line, so no sync or trigger event ever occurs.
- R3: Synchronous mode applies when `src_sel` is nonzero and `trig_mode` = 0. An event on the selected line clears the counter to zero in the next cycle, whether or not `clk_en` is high. The cycle of the event is not counted.
- R4: Trigger mode applies when `src_sel` is nonzero and `trig_mode` = 1. The counter is held at zero (CS_ARMED) until the selected line pulses, then counts from zero. Further events while it is counting are ignored.
- R5: In trigger mode the counter returns to CS_ARMED at zero after a rollover, at the end of a PWM period, or once a one-shot pulse has completed. It then waits for the next trigger.
- R6: The counter advances, and compare matches are evaluated, only in cycles with `clk_en` = 1.
- R7: `match_irq` is high for one cycle, in the cycle after each counted cycle in which the counter equals `cmp_pri` or `cmp_sec`.
- R8: With `out_mode` = 01 (one-shot), `oc_out` rises after a primary match and falls after a secondary match. It then stays low until `arm` is pulsed.
- R9: With `out_mode` = 10 (repeat), `oc_out` rises after each primary match and falls after each secondary match, with no re-arming needed.
- R10: With `out_mode` = 11 (PWM), `oc_out` goes high when the counter restarts from zero and low after a primary match. A secondary match ends the period. With `clk_en` held high, this gives cmp_pri+1 high cycles in every cmp_sec+1. If cmp_pri >= cmp_sec, the output stays high.
- R11: With `out_mode` = 00, `oc_out` is low from the next cycle on.
- R12: During and right after reset, `oc_out` and `match_irq` are low. The counter starts in CS_FREE and the output starts in OS_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Count enable; the counter advances only when high |
| sync_src | input | 21 | Sync/trigger event lines |
| src_sel | input | 5 | 0 = free-running; v = line v-1; above 21 = no line |
| trig_mode | input | 1 | 1 = trigger mode, 0 = synchronous mode (nonzero select only) |
| out_mode | input | 2 | 00 off, 01 one-shot, 10 repeat, 11 PWM |
| arm | input | 1 | Re-arms the one-shot after it completes |
| cmp_pri | input | 16 | Primary compare value |
| cmp_sec | input | 16 | Secondary compare value (PWM period) |
| oc_out | output | 1 | Compare output pin |
| match_irq | output | 1 | One-cycle compare match pulse |

## Verification
The assertions assume that `out_mode`, `cmp_pri`, `cmp_sec` and the mode select stay stable over the window a property spans. They also assume that event lines are single-cycle pulses. The directed stimulus changes configuration only at the falling edge, between test windows, and drives each event line high for exactly one cycle. The one exception is the out-of-range select test, which pulses all 21 lines at once to show that none of them is picked up. Mode changes that must reach a known counter state go through a deliberate `trig_mode` toggle. This passes through CS_FREE into CS_ARMED, so the counter is cleared before the next window is observed.

// File: rtl/occh_pkg.sv
package occh_pkg;

    typedef enum logic [1:0] {
        CS_FREE  = 2'd0,
        CS_ARMED = 2'd1,
        CS_RUN   = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        OS_WAIT = 2'd0,
        OS_HIGH = 2'd1,
        OS_DONE = 2'd2
    } out_state_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_SINGLE = 2'b01,
        OM_REPEAT = 2'b10,
        OM_PWM    = 2'b11
    } out_mode_e;

endpackage

// File: rtl/occh_src_sel.sv
module occh_src_sel #(
    parameter int NSRC  = 21,
    parameter int SEL_W = 5
) (
    input  logic [NSRC-1:0]  sync_src,
    input  logic [SEL_W-1:0] src_sel,
    output logic             slaved,
    output logic             src_evt
);

    // A select of zero means the counter is on its own.
    assign slaved = (src_sel != '0);

    // Select v picks line v-1; values past the last line pick nothing.
    always_comb begin
        src_evt = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_sel == SEL_W'(i + 1)) begin
                src_evt = sync_src[i];
            end
        end
    end

endmodule

// File: rtl/occh_counter.sv
module occh_counter
    import occh_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             slaved,
    input  logic             trig_mode,
    input  logic             src_evt,
    input  logic             pwm_mode,
    input  logic             shot_done,
    input  logic [CNT_W-1:0] cmp_sec,
    output logic [CNT_W-1:0] cnt,
    output cnt_state_e       state,
    output logic             tick,
    output logic             restart
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             trig_on;
    logic             sync_on;
    logic             period_end;

    assign trig_on    = slaved && trig_mode;
    assign sync_on    = slaved && !trig_mode;
    assign period_end = (cnt == CNT_MAX) || (pwm_mode && (cnt == cmp_sec));

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        tick      = 1'b0;
        restart   = 1'b0;
        unique case (state)
            CS_FREE: begin
                if (trig_on) begin
                    state_nxt = CS_ARMED;
                    cnt_nxt   = '0;
                end else if (sync_on && src_evt) begin
                    cnt_nxt = '0;
                    restart = 1'b1;
                end else if (clk_en) begin
                    tick    = 1'b1;
                    restart = period_end;
                    cnt_nxt = period_end ? '0 : cnt + CNT_W'(1);
                end
            end
            CS_ARMED: begin
                cnt_nxt = '0;
                if (!trig_on) begin
                    state_nxt = CS_FREE;
                end else if (src_evt) begin
                    state_nxt = CS_RUN;
                    restart   = 1'b1;
                end
            end
            CS_RUN: begin
                if (!trig_on) begin
                    state_nxt = CS_FREE;
                end else if (shot_done) begin
                    state_nxt = CS_ARMED;
                    cnt_nxt   = '0;
                end else if (clk_en) begin
                    tick = 1'b1;
                    if (period_end) begin
                        state_nxt = CS_ARMED;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
            end
            default: state_nxt = CS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_FREE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

endmodule

// File: rtl/occh_output.sv
module occh_output
    import occh_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  out_mode_e        mode,
    input  logic             arm,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_pri,
    input  logic [CNT_W-1:0] cmp_sec,
    output out_state_e       state,
    output logic             oc_out,
    output logic             match_irq
);

    out_state_e state_nxt;
    logic       hit_pri;
    logic       hit_sec;

    assign hit_pri = tick && (cnt == cmp_pri);
    assign hit_sec = tick && (cnt == cmp_sec);

    always_comb begin
        state_nxt = state;
        unique case (state)
            OS_WAIT: begin
                unique case (mode)
                    OM_OFF:    state_nxt = OS_WAIT;
                    OM_SINGLE: if (hit_pri) state_nxt = OS_HIGH;
                    OM_REPEAT: if (hit_pri) state_nxt = OS_HIGH;
                    OM_PWM:    if (restart) state_nxt = OS_HIGH;
                    default:   state_nxt = OS_WAIT;
                endcase
            end
            OS_HIGH: begin
                unique case (mode)
                    OM_OFF:    state_nxt = OS_WAIT;
                    OM_SINGLE: if (hit_sec) state_nxt = OS_DONE;
                    OM_REPEAT: if (hit_sec) state_nxt = OS_WAIT;
                    OM_PWM:    if (!restart && hit_pri) state_nxt = OS_WAIT;
                    default:   state_nxt = OS_WAIT;
                endcase
            end
            OS_DONE: begin
                if (mode != OM_SINGLE || arm) begin
                    state_nxt = OS_WAIT;
                end
            end
            default: state_nxt = OS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OS_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_irq <= 1'b0;
        end else begin
            match_irq <= hit_pri || hit_sec;
        end
    end

    always_comb begin
        oc_out = (state == OS_HIGH);
    end

endmodule

// File: rtl/occh_timer.sv
module occh_timer
    import occh_pkg::*;
#(
    parameter int NSRC  = 21,
    parameter int SEL_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [NSRC-1:0]  sync_src,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             trig_mode,
    input  logic [1:0]       out_mode,
    input  logic             arm,
    input  logic [CNT_W-1:0] cmp_pri,
    input  logic [CNT_W-1:0] cmp_sec,
    output logic             oc_out,
    output logic             match_irq
);

    out_mode_e        omode;
    logic             slaved;
    logic             src_evt;
    logic [CNT_W-1:0] cnt;
    cnt_state_e       cstate;
    out_state_e       ostate;
    logic             tick;
    logic             restart;
    logic             shot_done;

    assign omode = out_mode_e'(out_mode);

    // A finished one-shot keeps a triggered counter parked.
    assign shot_done = (ostate == OS_DONE) && (omode == OM_SINGLE);

    occh_src_sel #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W)
    ) u_sel (
        .sync_src (sync_src),
        .src_sel  (src_sel),
        .slaved   (slaved),
        .src_evt  (src_evt)
    );

    occh_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .slaved    (slaved),
        .trig_mode (trig_mode),
        .src_evt   (src_evt),
        .pwm_mode  (omode == OM_PWM),
        .shot_done (shot_done),
        .cmp_sec   (cmp_sec),
        .cnt       (cnt),
        .state     (cstate),
        .tick      (tick),
        .restart   (restart)
    );

    occh_output #(
        .CNT_W (CNT_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (omode),
        .arm       (arm),
        .tick      (tick),
        .restart   (restart),
        .cnt       (cnt),
        .cmp_pri   (cmp_pri),
        .cmp_sec   (cmp_sec),
        .state     (ostate),
        .oc_out    (oc_out),
        .match_irq (match_irq)
    );

endmodule

// File: rtl/occh_checker.sv
module occh_checker
    import occh_pkg::*;
#(
    parameter int SEL_W = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic [SEL_W-1:0] src_sel,
    input logic             trig_mode,
    input logic [1:0]       out_mode,
    input logic             arm,
    input logic             src_evt,
    input logic [CNT_W-1:0] cmp_pri,
    input logic [CNT_W-1:0] cmp_sec,
    input logic [CNT_W-1:0] cnt,
    input cnt_state_e       cstate,
    input out_state_e       ostate,
    input logic             tick,
    input logic             oc_out,
    input logic             match_irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R1: a counted cycle below the top value steps the counter by one
    a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != CNT_MAX && out_mode != 2'b11) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R4: while waiting for a trigger the counter is pinned at zero
    a_r4_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == CS_ARMED && trig_mode && src_sel != '0) |=> (cnt == '0));

    // R5: rollover of a triggered run parks the counter again
    a_r5_roll_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == CS_RUN && tick && cnt == CNT_MAX) |=> (cstate == CS_ARMED));

    // R6: without enable and without an event the free counter holds
    a_r6_hold_no_en: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == CS_FREE && !clk_en && !src_evt && !(trig_mode && src_sel != '0))
        |=> $stable(cnt));

    // R7: every match pulse follows a counted cycle that hit a compare value
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> $past(tick && (cnt == cmp_pri || cnt == cmp_sec)));

    // R8: a finished one-shot stays finished until re-armed
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ostate == OS_DONE && out_mode == 2'b01 && !arm) |=> (ostate == OS_DONE && !oc_out));

    // R10: the secondary value closes a free PWM period
    a_r10_period_close: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == CS_FREE && out_mode == 2'b11 && tick && cnt == cmp_sec) |=> (cnt == '0));

    // R11: output mode off forces the pin low
    a_r11_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00) |=> !oc_out);

endmodule

bind occh_timer occh_checker #(
    .SEL_W (SEL_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .src_sel   (src_sel),
    .trig_mode (trig_mode),
    .out_mode  (out_mode),
    .arm       (arm),
    .src_evt   (src_evt),
    .cmp_pri   (cmp_pri),
    .cmp_sec   (cmp_sec),
    .cnt       (cnt),
    .cstate    (cstate),
    .ostate    (ostate),
    .tick      (tick),
    .oc_out    (oc_out),
    .match_irq (match_irq)
);

// File: tb/occh_timer_tb.sv
`timescale 1ns/1ps
module occh_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en;
    logic [20:0] sync_src;
    logic [4:0]  src_sel;
    logic        trig_mode;
    logic [1:0]  out_mode;
    logic        arm;
    logic [15:0] cmp_pri;
    logic [15:0] cmp_sec;
    logic        oc_out;
    logic        match_irq;

    int n_tests = 0;
    int n_fail  = 0;

    logic s_out [1:128];
    logic s_irq [1:128];
    logic e_out [1:128];
    logic e_irq [1:128];

    always #2.5 clk = ~clk;

    occh_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sync_src  (sync_src),
        .src_sel   (src_sel),
        .trig_mode (trig_mode),
        .out_mode  (out_mode),
        .arm       (arm),
        .cmp_pri   (cmp_pri),
        .cmp_sec   (cmp_sec),
        .oc_out    (oc_out),
        .match_irq (match_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge. Pulses one line; sample k is taken k falling
    // edges later, so it shows the result of k rising edges after the event.
    task automatic capture(input int line, input int n, input int off_from,
                           input int off_to, input int side_line, input int side_k);
        clk_en = !(0 >= off_from && 0 < off_to);
        if (line >= 0) sync_src[line] = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 1 && line >= 0) sync_src[line] = 1'b0;
            if (side_line >= 0) sync_src[side_line] = (k == side_k);
            clk_en = !(k >= off_from && k < off_to);
            s_out[k] = oc_out;
            s_irq[k] = match_irq;
        end
        sync_src = '0;
        clk_en   = 1'b1;
    endtask

    task automatic set_exp(input int n, input int hi_lo, input int hi_hi,
                           input int irq_a, input int irq_b);
        for (int k = 1; k <= n; k++) begin
            e_out[k] = (k >= hi_lo && k <= hi_hi);
            e_irq[k] = (k == irq_a || k == irq_b);
        end
    endtask

    task automatic compare(input int n, input string rq_out, input string rq_irq);
        int bad_o = 0;
        int bad_i = 0;
        for (int k = n; k >= 1; k--) begin
            if (s_out[k] !== e_out[k]) bad_o = k;
            if (s_irq[k] !== e_irq[k]) bad_i = k;
        end
        chk(bad_o == 0, rq_out, bad_o == 0 ? 0 : int'(s_out[bad_o]),
            bad_o == 0 ? 0 : int'(e_out[bad_o]));
        if (bad_o != 0) $display("  output sample index %0d", bad_o);
        chk(bad_i == 0, rq_irq, bad_i == 0 ? 0 : int'(s_irq[bad_i]),
            bad_i == 0 ? 0 : int'(e_irq[bad_i]));
        if (bad_i != 0) $display("  irq sample index %0d", bad_i);
    endtask

    task automatic pulse_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; clk_en = 1'b1; sync_src = '0; src_sel = '0;
        trig_mode = 1'b0; out_mode = 2'b00; arm = 1'b0;
        cmp_pri = 16'd100; cmp_sec = 16'd200;
        repeat (4) @(negedge clk);
        chk(oc_out == 1'b0, "R12 out in reset", int'(oc_out), 0);
        chk(match_irq == 1'b0, "R12 irq in reset", int'(match_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(oc_out == 1'b0 && match_irq == 1'b0, "R12 after reset",
            int'({oc_out, match_irq}), 0);
    endtask

    task automatic t_sync();
        src_sel = 5'd3; trig_mode = 1'b0; out_mode = 2'b00;
        cmp_pri = 16'd5; cmp_sec = 16'd9;
        capture(2, 30, 0, 0, -1, 0);
        set_exp(30, 0, -1, 7, 11);
        compare(30, "R11 off low", "R3 R7 sync clear");
        // R6: enable dropped for five edges delays both matches by five
        capture(2, 30, 2, 7, -1, 0);
        set_exp(30, 0, -1, 12, 16);
        compare(30, "R11 off low", "R6 enable gating");
        // R3: the clear also happens with enable low
        capture(2, 30, 0, 4, -1, 0);
        set_exp(30, 0, -1, 10, 14);
        compare(30, "R11 off low", "R3 clear while disabled");
        // R2: a pulse on an unselected line leaves the count alone
        capture(2, 30, 0, 0, 4, 3);
        set_exp(30, 0, -1, 7, 11);
        compare(30, "R11 off low", "R2 unselected line");
    endtask

    task automatic t_out_of_range();
        int seen = 0;
        src_sel = 5'd25; trig_mode = 1'b1;
        @(negedge clk);
        sync_src = '1;
        @(negedge clk);
        sync_src = '0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (match_irq) seen++;
        end
        chk(seen == 0, "R2 select 25 never triggers", seen, 0);
    endtask

    task automatic t_trigger();
        int seen = 0;
        src_sel = 5'd2;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (match_irq) seen++;
        end
        chk(seen == 0, "R4 held before trigger", seen, 0);
        // A second event at k=4 must not restart the running count.
        capture(1, 30, 0, 0, 1, 4);
        set_exp(30, 0, -1, 7, 11);
        compare(30, "R11 off low", "R4 trigger start, retrigger ignored");
    endtask

    task automatic t_trig_pwm();
        trig_mode = 1'b0;
        @(negedge clk);
        trig_mode = 1'b1; out_mode = 2'b11; cmp_pri = 16'd3; cmp_sec = 16'd6;
        repeat (3) @(negedge clk);
        capture(1, 40, 0, 0, -1, 0);
        set_exp(40, 1, 4, 5, 8);
        compare(40, "R10 trig PWM shape", "R5 period end rearms");
    endtask

    task automatic t_trig_single();
        out_mode = 2'b01; cmp_pri = 16'd2; cmp_sec = 16'd4;
        pulse_arm();
        capture(1, 20, 0, 0, -1, 0);
        set_exp(20, 4, 5, 4, 6);
        compare(20, "R8 trig one-shot", "R7 trig one-shot irq");
        pulse_arm();
        capture(1, 20, 0, 0, -1, 0);
        set_exp(20, 4, 5, 4, 6);
        compare(20, "R5 one-shot done parks counter", "R5 irq after retrigger");
    endtask

    task automatic t_sync_single();
        trig_mode = 1'b0; src_sel = 5'd1; out_mode = 2'b01;
        cmp_pri = 16'd4; cmp_sec = 16'd8;
        pulse_arm();
        capture(0, 20, 0, 0, -1, 0);
        set_exp(20, 6, 9, 6, 10);
        compare(20, "R8 one-shot pulse", "R7 one-shot irq");
        capture(0, 20, 0, 0, -1, 0);
        set_exp(20, 0, -1, 6, 10);
        compare(20, "R8 stays low unarmed", "R7 irq unarmed");
        pulse_arm();
        capture(0, 20, 0, 0, -1, 0);
        set_exp(20, 6, 9, 6, 10);
        compare(20, "R8 re-armed pulse", "R7 re-armed irq");
    endtask

    task automatic t_repeat();
        out_mode = 2'b10; cmp_pri = 16'd2; cmp_sec = 16'd5;
        capture(0, 20, 0, 0, -1, 0);
        set_exp(20, 4, 6, 4, 7);
        compare(20, "R9 repeat first", "R7 repeat irq");
        capture(0, 20, 0, 0, -1, 0);
        set_exp(20, 4, 6, 4, 7);
        compare(20, "R9 repeat again", "R7 repeat irq again");
    endtask

    task automatic t_pwm();
        out_mode = 2'b11; cmp_pri = 16'd3; cmp_sec = 16'd7;
        capture(0, 40, 0, 0, -1, 0);
        for (int k = 1; k <= 40; k++) begin
            e_out[k] = (((k - 1) % 8) < 4);
            e_irq[k] = (k >= 5) && (((k - 1) % 4) == 0);
        end
        compare(40, "R10 PWM 4 of 8", "R7 PWM irq");
        cmp_pri = 16'd9;
        capture(0, 24, 0, 0, -1, 0);
        for (int k = 1; k <= 24; k++) begin
            e_out[k] = 1'b1;
            e_irq[k] = (k == 9) || (k == 17);
        end
        compare(24, "R10 duty above period stays high", "R7 irq secondary only");
        out_mode = 2'b00;
        @(negedge clk);
        chk(oc_out == 1'b0, "R11 off forces low", int'(oc_out), 0);
    endtask

    task automatic t_wrap();
        int hits [3];
        int nh = 0;
        out_mode = 2'b00; cmp_pri = 16'd5; cmp_sec = 16'd9; src_sel = 5'd1;
        sync_src[0] = 1'b1;
        @(negedge clk);
        sync_src[0] = 1'b0;
        src_sel = 5'd0;
        hits = '{0, 0, 0};
        if (match_irq) begin hits[0] = 1; nh = 1; end
        for (int k = 2; k <= 65600 && nh < 3; k++) begin
            @(negedge clk);
            if (match_irq) begin
                hits[nh] = k;
                nh++;
            end
        end
        chk(hits[0] == 7, "R1 first match", hits[0], 7);
        chk(hits[1] == 11, "R1 second match", hits[1], 11);
        chk(hits[2] == 65543, "R1 wrap period", hits[2], 65543);
    endtask

    initial begin
        sync_src = '0;
        t_reset();
        t_sync();
        t_out_of_range();
        t_trigger();
        t_trig_pwm();
        t_trig_single();
        t_sync_single();
        t_repeat();
        t_pwm();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule